// File: doc/BRIEF.md
# Transmit Checksum Insertion Unit

This unit sits in a transmit path and places a 16-bit ones-complement checksum into an outgoing frame before it leaves. For each frame a five-word sideband header comes in first on a word port. It carries an enable flag, the byte offset where summing starts, the byte offset where the result goes, and a 16-bit seed value. The frame bytes then arrive on a byte-wide stream. They are stored in an internal buffer and summed as they come in. Once the last byte is in, the sum is folded, complemented and patched into the buffered copy on its way out of the byte-wide output stream.

Three static configuration inputs control whether frames are sent at all and whether frames just above the standard size are allowed. A dropped frame still consumes its header. A one-cycle status pulse marks each frame that has been fully sent.

Top module: `tci_tx_csum_insert`

## Requirements
- R1: Frame bytes are refused (s_tready low) until all five control words of the header have been accepted. A new header is accepted only after the previous frame has been sent or dropped.
- R2: When bit 0 of control word 0 is 0, the frame is sent byte for byte unchanged.
- R3: Control word 1 carries the sum start offset in bits 31:16 and the write offset in bits 15:0. Bytes from the start offset to the last byte are summed as big-endian 16-bit words, and the pairing begins at the start offset.
- R4: Bits 15:0 of control word 2 are added to the sum. The carries are folded back into 16 bits twice, and the ones complement of the result is the inserted value.
- R5: The high byte of the result replaces the byte at the write offset, and the low byte replaces the next byte. Positions that lie at or beyond the frame length are not written, so the frame length never changes.
- R6: When the summed range holds an odd number of bytes, the last byte is taken as the high half of a word whose low half is zero.
- R7: While tx_enable is low, a frame is taken in and then discarded. It produces no output and no tx_done, and its header is used up.
- R8: When jumbo_enable and vlan_enable are both low, frames of 1519 to 1522 bytes are discarded. Frames of 1518 or 1523 bytes are sent. Setting either enable lets the 1519 to 1522 byte frames through.
- R9: Output starts only after the last input byte has been accepted. m_tlast is set on the final byte only. While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values.
- R10: tx_done is high for exactly one cycle, in the cycle after the handshake of each sent frame's last byte.
- R11: After reset, ctl_ready is 1, and s_tready, m_tvalid and tx_done are 0. A header that was only partly received before the reset is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Frames are sent when high and discarded when low |
| jumbo_enable | input | 1 | Allows frames longer than the standard size |
| vlan_enable | input | 1 | Allows tagged-size frames (1519 to 1522 bytes) |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted when high together with ctl_valid |
| ctl_data | input | 32 | Control header word, five per frame, in order |
| s_tvalid | input | 1 | Input stream byte valid |
| s_tready | output | 1 | Input stream ready |
| s_tdata | input | 8 | Input stream byte |
| s_tlast | input | 1 | Marks the last byte of the input frame |
| m_tvalid | output | 1 | Output stream byte valid |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | 8 | Output stream byte, with the checksum patched in |
| m_tlast | output | 1 | Marks the last byte of the output frame |
| tx_done | output | 1 | One-cycle pulse after each frame is sent |

## Verification
The bench builds the unit with its default parameters: a 2048-byte buffer, a standard size limit of 1518 bytes and a tagged size limit of 1522 bytes. With these values the size-window boundaries (1518, 1519, 1522 and 1523 bytes) fit in the buffer and can be tested with real frames under each enable setting. The short frames in the table cover odd and even summed ranges, all-ones data with an all-ones seed so that the carries fold, write offsets at and past the frame end, and output backpressure.

// File: rtl/tci_pkg.sv
// Shared types for the transmit checksum insertion unit.
// Assumes: header word order is fixed (flag, offsets, seed, two spare).
package tci_pkg;
    localparam int HDR_WORDS = 5;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_FOLD = 2'd1,
        ST_SEND = 2'd2
    } tci_state_e;

    typedef struct packed {
        logic        en;
        logic [15:0] start;
        logic [15:0] wroff;
        logic [15:0] seed;
    } tci_hdr_t;
endpackage

// File: rtl/tci_hdr_capture.sv
// Collects the five control words of one frame header and holds the
// decoded fields until the frame is finished (release_i).
// Assumes: words arrive in order; words 3 and 4 carry nothing used here.
module tci_hdr_capture
    import tci_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_valid,
    input  logic [31:0] ctl_data,
    output logic        ctl_ready,
    input  logic        release_i,
    output logic        hdr_full,
    output tci_hdr_t    hdr
);
    localparam int IDX_W = $clog2(HDR_WORDS);

    logic [IDX_W-1:0] word_idx;
    logic             take;

    assign ctl_ready = !hdr_full;
    assign take      = ctl_valid && ctl_ready;

    // Track word position and decode the fields that matter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
            hdr_full <= 1'b0;
            hdr      <= '0;
        end else begin
            if (release_i) hdr_full <= 1'b0;
            if (take) begin
                case (word_idx)
                    IDX_W'(0): hdr.en <= ctl_data[0];
                    IDX_W'(1): begin
                        hdr.start <= ctl_data[31:16];
                        hdr.wroff <= ctl_data[15:0];
                    end
                    IDX_W'(2): hdr.seed <= ctl_data[15:0];
                    default: ;
                endcase
                if (word_idx == IDX_W'(HDR_WORDS - 1)) begin
                    word_idx <= '0;
                    hdr_full <= 1'b1;
                end else begin
                    word_idx <= word_idx + 1'b1;
                end
            end
        end
    end

    AST_HDR_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_full) |-> $past(ctl_valid && ctl_ready)); // R1
endmodule

// File: rtl/tci_csum_accum.sv
// Accumulates big-endian 16-bit words from the start offset onward as
// bytes stream in, then folds in the seed and complements on fold_en.
// Assumes: byte_idx counts from 0 per frame; clr arrives between frames.
module tci_csum_accum #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [7:0]       byte_dat,
    input  logic [LEN_W-1:0] byte_idx,
    input  logic [15:0]      start,
    input  logic [15:0]      seed,
    input  logic             fold_en,
    output logic [15:0]      csum
);
    localparam int ACC_W = LEN_W + 16;

    logic [ACC_W-1:0] acc;
    logic [15:0]      idx16;
    logic             in_range;
    logic             low_half;
    logic [15:0]      addend;
    logic [31:0]      total;
    logic [16:0]      fold1;
    logic [15:0]      fold2;

    // Place each byte in the high or low half relative to the start.
    always_comb begin
        idx16    = 16'(byte_idx);
        in_range = idx16 >= start;
        low_half = idx16[0] ^ start[0];
        addend   = low_half ? {8'h00, byte_dat} : {byte_dat, 8'h00};
    end

    // Add the seed and fold the carries back twice.
    always_comb begin
        total = 32'(acc) + 32'(seed);
        fold1 = 17'(total[15:0]) + 17'(total[31:16]);
        fold2 = fold1[15:0] + 16'(fold1[16]);
    end

    // Running sum over the selected range.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (byte_vld && in_range) acc <= acc + ACC_W'(addend);
    end

    // Capture the complemented result once the frame is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) csum <= '0;
        else if (fold_en) csum <= ~fold2;
    end

    AST_NO_ADD_IN_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> !fold_en); // R4
endmodule

// File: rtl/tci_frame_store.sv
// Byte buffer that holds one frame: one write port, one read port with
// an asynchronous read.
// Assumes: reads and writes never target the same frame at the same time.
module tci_frame_store #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Store each accepted byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tci_tx_csum_insert.sv
// Top of the transmit checksum insertion unit: store-and-forward of one
// frame, checksum accumulated on ingest, patched into the output.
// Assumes: no frame exceeds BUF_DEPTH bytes; config inputs are static
// while a frame is in flight.
module tci_tx_csum_insert
    import tci_pkg::*;
#(
    parameter int BUF_DEPTH = 2048,
    parameter int STD_MAX   = 1518,
    parameter int TAG_MAX   = 1522
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_enable,
    input  logic        jumbo_enable,
    input  logic        vlan_enable,
    input  logic        ctl_valid,
    output logic        ctl_ready,
    input  logic [31:0] ctl_data,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic [7:0]  s_tdata,
    input  logic        s_tlast,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic [7:0]  m_tdata,
    output logic        m_tlast,
    output logic        tx_done
);
    localparam int ADDR_W = $clog2(BUF_DEPTH);
    localparam int LEN_W  = ADDR_W + 1;

    tci_state_e       state;
    tci_hdr_t         hdr;
    logic             hdr_full;
    logic [LEN_W-1:0] wr_cnt;
    logic [LEN_W-1:0] rd_cnt;
    logic             in_fire;
    logic             out_fire;
    logic             drop_frame;
    logic             release_hdr;
    logic [15:0]      csum;
    logic [7:0]       rd_byte;
    logic [16:0]      rd_pos;

    assign s_tready    = (state == ST_FILL) && hdr_full;
    assign in_fire     = s_tvalid && s_tready;
    assign m_tvalid    = (state == ST_SEND);
    assign m_tlast     = m_tvalid && (rd_cnt == wr_cnt - 1'b1);
    assign out_fire    = m_tvalid && m_tready;
    assign release_hdr = ((state == ST_FOLD) && drop_frame) || (out_fire && m_tlast);

    // Decide discard from config and the received length.
    always_comb begin
        drop_frame = !tx_enable;
        if (!jumbo_enable && !vlan_enable &&
            wr_cnt > LEN_W'(STD_MAX) && wr_cnt <= LEN_W'(TAG_MAX))
            drop_frame = 1'b1;
    end

    // Patch the checksum bytes over the stored frame on the way out.
    always_comb begin
        rd_pos  = 17'(rd_cnt);
        m_tdata = rd_byte;
        if (hdr.en && rd_pos == 17'(hdr.wroff))
            m_tdata = csum[15:8];
        else if (hdr.en && rd_pos == 17'(hdr.wroff) + 17'd1)
            m_tdata = csum[7:0];
    end

    // Frame sequencing: fill, fold, send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FILL;
            wr_cnt  <= '0;
            rd_cnt  <= '0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= out_fire && m_tlast;
            case (state)
                ST_FILL: if (in_fire) begin
                    wr_cnt <= wr_cnt + 1'b1;
                    if (s_tlast) state <= ST_FOLD;
                end
                ST_FOLD: begin
                    rd_cnt <= '0;
                    if (drop_frame) begin
                        state  <= ST_FILL;
                        wr_cnt <= '0;
                    end else begin
                        state <= ST_SEND;
                    end
                end
                ST_SEND: if (out_fire) begin
                    rd_cnt <= rd_cnt + 1'b1;
                    if (m_tlast) begin
                        state  <= ST_FILL;
                        wr_cnt <= '0;
                    end
                end
                default: state <= ST_FILL;
            endcase
        end
    end

    tci_hdr_capture u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .ctl_ready (ctl_ready),
        .release_i (release_hdr),
        .hdr_full  (hdr_full),
        .hdr       (hdr)
    );

    tci_csum_accum #(.LEN_W(LEN_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (release_hdr),
        .byte_vld (in_fire),
        .byte_dat (s_tdata),
        .byte_idx (wr_cnt),
        .start    (hdr.start),
        .seed     (hdr.seed),
        .fold_en  (state == ST_FOLD),
        .csum     (csum)
    );

    tci_frame_store #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (in_fire),
        .waddr (wr_cnt[ADDR_W-1:0]),
        .wdata (s_tdata),
        .raddr (rd_cnt[ADDR_W-1:0]),
        .rdata (rd_byte)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> wr_cnt < LEN_W'(BUF_DEPTH)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done); // R10
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(out_fire && m_tlast)); // R10
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FOLD) && drop_frame |=> !m_tvalid && !tx_done); // R7
endmodule

// File: tb/tci_tx_csum_insert_tb.sv
module tci_tx_csum_insert_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b1, jumbo_enable = 1'b0, vlan_enable = 1'b0;
    logic        ctl_valid = 1'b0, ctl_ready;
    logic [31:0] ctl_data = '0;
    logic        s_tvalid = 1'b0, s_tready, s_tlast = 1'b0;
    logic [7:0]  s_tdata = '0;
    logic        m_tvalid, m_tready = 1'b0, m_tlast;
    logic [7:0]  m_tdata;
    logic        tx_done;

    always #10 clk = ~clk;

    tci_tx_csum_insert u_dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable),
        .jumbo_enable(jumbo_enable), .vlan_enable(vlan_enable),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .tx_done(tx_done)
    );

    typedef struct packed {
        logic        en;
        logic [15:0] start;
        logic [15:0] wroff;
        logic [15:0] seed;
        logic [15:0] len;
        logic [7:0]  pat;
        logic [7:0]  mult;
        logic        txen;
        logic        jumbo;
        logic        vlan;
        logic        bp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd14, 16'd24, 16'h0000, 16'd60,   8'h03, 8'd29, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b0, 16'd0,  16'd2,  16'h1234, 16'd40,   8'h11, 8'd7,  1'b1, 1'b0, 1'b0, 1'b1}, // R2
        '{1'b1, 16'd0,  16'd0,  16'hFFFF, 16'd21,   8'hFF, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0}, // R4 R6
        '{1'b1, 16'd20, 16'd40, 16'h8001, 16'd64,   8'hF0, 8'd31, 1'b1, 1'b0, 1'b0, 1'b1}, // R4
        '{1'b1, 16'd5,  16'd59, 16'h00AA, 16'd60,   8'h5A, 8'd13, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b1, 16'd0,  16'd100,16'h0001, 16'd50,   8'h22, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1}, // R5
        '{1'b1, 16'd0,  16'd4,  16'h0000, 16'd1,    8'hC3, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0}, // R6
        '{1'b1, 16'd0,  16'd2,  16'h0000, 16'd30,   8'h44, 8'd5,  1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b1, 16'd14, 16'd30, 16'h0000, 16'd1519, 8'h01, 8'd9,  1'b1, 1'b0, 1'b0, 1'b0}, // R8
        '{1'b1, 16'd14, 16'd30, 16'h0000, 16'd1522, 8'h02, 8'd9,  1'b1, 1'b0, 1'b0, 1'b0}, // R8
        '{1'b1, 16'd14, 16'd30, 16'h0102, 16'd1518, 8'h03, 8'd9,  1'b1, 1'b0, 1'b0, 1'b0}, // R8
        '{1'b1, 16'd14, 16'd30, 16'h0304, 16'd1523, 8'h04, 8'd9,  1'b1, 1'b0, 1'b0, 1'b1}, // R8
        '{1'b1, 16'd14, 16'd30, 16'h0506, 16'd1520, 8'h05, 8'd9,  1'b1, 1'b0, 1'b1, 1'b0}, // R8
        '{1'b1, 16'd15, 16'd31, 16'h0708, 16'd1521, 8'h06, 8'd9,  1'b1, 1'b1, 1'b0, 1'b0}  // R8
    };

    logic [7:0] fr [0:2047];
    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;

    always @(posedge clk) if (rst_n && tx_done) done_cnt <= done_cnt + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] w);
        ctl_valid = 1'b1;
        ctl_data  = w;
        while (!ctl_ready) @(negedge clk);
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic send_hdr(input logic en, input logic [15:0] st,
                            input logic [15:0] wo, input logic [15:0] sd);
        put_word({31'h0, en});
        put_word({st, wo});
        put_word({16'h0, sd});
        put_word(32'h0);
        put_word(32'h0);
    endtask

    task automatic send_frame(input int len);
        for (int i = 0; i < len; i++) begin
            s_tvalid = 1'b1;
            s_tdata  = fr[i];
            s_tlast  = (i == len - 1);
            while (!s_tready) @(negedge clk);
            if (i == len - 1)
                chk(!m_tvalid, "R9", "output before last input byte", m_tvalid, 0);
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    function automatic logic [15:0] exp_csum(input int len, input int st, input logic [15:0] sd);
        int unsigned s = 0;
        for (int i = st; i < len; i++)
            s += ((i - st) % 2 == 0) ? (32'(fr[i]) << 8) : 32'(fr[i]);
        s += 32'(sd);
        s = (s & 32'hFFFF) + (s >> 16);
        s = (s & 32'hFFFF) + (s >> 16);
        return ~s[15:0];
    endfunction

    task automatic recv_check(input int len, input logic en, input int wo,
                              input logic [15:0] cs, input bit bp, input string req);
        int idx = 0, guard = 0, bad = 0, bad_i = -1;
        logic [7:0] act_b = 0, exp_b = 0, held = 0;
        bit holding = 0;
        int d0 = done_cnt;
        while (idx < len && guard < len * 4 + 100) begin
            m_tready = bp ? (guard % 3 != 1) : 1'b1;
            if (holding && m_tdata != held) bad++;
            holding = 0;
            if (m_tvalid && m_tready) begin
                logic [7:0] e;
                e = fr[idx];
                if (en && idx == wo) e = cs[15:8];
                else if (en && idx == wo + 1) e = cs[7:0];
                if (m_tdata != e || m_tlast != (idx == len - 1)) begin
                    if (bad_i < 0) begin bad_i = idx; act_b = m_tdata; exp_b = e; end
                    bad++;
                end
                idx++;
            end else if (m_tvalid) begin
                holding = 1;
                held = m_tdata;
            end
            @(negedge clk);
            guard++;
        end
        m_tready = 1'b0;
        chk(bad == 0, req, $sformatf("frame data len=%0d first bad byte %0d", len, bad_i), act_b, exp_b);
        chk(idx == len, "R9", "byte count", idx, len);
        chk(tx_done == 1'b1 && done_cnt == d0, "R10", "tx_done after last", tx_done, 1);
        @(negedge clk);
        chk(tx_done == 1'b0 && !m_tvalid, "R10", "tx_done single pulse", tx_done, 0);
    endtask

    task automatic expect_drop(input string req);
        int d0 = done_cnt;
        bit seen = 0;
        for (int k = 0; k < 30; k++) begin
            if (m_tvalid || tx_done) seen = 1;
            @(negedge clk);
        end
        chk(!seen && done_cnt == d0, req, "dropped frame produced output", seen, 0);
    endtask

    task automatic fill(input int len, input logic [7:0] pat, input logic [7:0] mult);
        for (int i = 0; i < len; i++) fr[i] = 8'(i * int'(mult) + int'(pat));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(ctl_ready && !s_tready && !m_tvalid && !tx_done, "R11", "reset outputs",
            {ctl_ready, s_tready, m_tvalid, tx_done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_ready && !s_tready && !m_tvalid && !tx_done, "R11", "after reset release",
            {ctl_ready, s_tready, m_tvalid, tx_done}, 4'b1000);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            bit drop;
            string req;
            tx_enable    = t.txen;
            jumbo_enable = t.jumbo;
            vlan_enable  = t.vlan;
            fill(int'(t.len), t.pat, t.mult);
            drop = !t.txen || (!t.jumbo && !t.vlan && t.len > 1518 && t.len <= 1522);
            req = (v == 0) ? "R3" : (v == 1) ? "R2" : (v == 2) ? "R4" : (v == 3) ? "R4" :
                  (v < 6) ? "R5" : (v == 6) ? "R6" : (v == 7) ? "R7" : "R8";
            send_hdr(t.en, t.start, t.wroff, t.seed);
            send_frame(int'(t.len));
            if (drop) expect_drop(req);
            else recv_check(int'(t.len), t.en, int'(t.wroff),
                            exp_csum(int'(t.len), int'(t.start), t.seed), t.bp, req);
        end
        tx_enable = 1'b1; jumbo_enable = 1'b0; vlan_enable = 1'b0;

        // R1: frame bytes held off until the fifth control word
        put_word(32'h1);
        put_word({16'd2, 16'd0});
        put_word(32'h0000_00FF);
        put_word(32'h0);
        repeat (2) @(negedge clk);
        chk(!s_tready, "R1", "s_tready with 4 of 5 words", s_tready, 0);
        put_word(32'h0);
        chk(s_tready && !ctl_ready, "R1", "ready after 5th word", {s_tready, ctl_ready}, 2'b10);
        fill(33, 8'h80, 8'd17);
        send_frame(33);
        recv_check(33, 1'b1, 0, exp_csum(33, 2, 16'h00FF), 1'b1, "R6");

        // R11: reset in the middle of a header forgets the partial words
        put_word(32'h1);
        put_word({16'd0, 16'd6});
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_ready && !s_tready && !m_tvalid, "R11", "mid-header reset",
            {ctl_ready, s_tready, m_tvalid}, 3'b100);
        send_hdr(1'b1, 16'd0, 16'd6, 16'h0F0F);
        fill(16, 8'h10, 8'd1);
        send_frame(16);
        recv_check(16, 1'b1, 6, exp_csum(16, 0, 16'h0F0F), 1'b0, "R11");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule